// File: doc/BRIEF.md
# Inbound Window Translation Register File

This block is the control register set of a bus host bridge together with the address translators that sit behind it. Software programs eight 32-bit registers through a small word-addressed register port: three window mapping registers, three secondary mapping registers, an identity register and a flags register. The three mapping registers set where each of three system-side memory windows lands in PCI memory space.

Each window has its own offset input and returns a translated PCI address plus an out-of-range flag, all combinational from the current register state. A fourth translator serves a fixed 1 MiB I/O window that always lands at PCI I/O address 0. The parameter `ALT_VARIANT` selects how a mapping register turns into a window base, and it also selects the window sizes. In the base variant a 4-bit page number supplies the top address nibble. In the alternate variant the register is masked down to the window's alignment.

Register accesses complete in one cycle. Read data and the error flag appear in the cycle after the request.

Top module: `ibw_xlat_regs`

## Requirements
- R1: After synchronous reset every one of the eight registers reads back as 0x00000000.
- R2: The register index is offset bits 4:2 for the defined word offsets 0x00 to 0x1C. Indices 0, 1 and 2 are window maps 0 to 2, index 3 is the identity register, index 4 is the flags register, and indices 5, 6 and 7 are secondary maps 0 to 2. A full-word write stores all 32 bits, and a read of the same offset returns them.
- R3: An access to an offset that is 0x20 or above, or whose bits 1:0 are not zero, is undefined. A read of it returns 0 with `reg_err`=1. A write to it changes no register and also gives `reg_err`=1.
- R4: An access whose byte enables are not all four set (`reg_be` != 4'hF) is rejected. It reads 0, writes nothing and raises `reg_err`.
- R5: `reg_rdata` and `reg_err` are registered. They reflect the access of the previous cycle, and both are 0 in the cycle after a cycle with no access.
- R6: With `ALT_VARIANT`=0 the base of window i is its map register bits 3:0 placed at PCI address bits 31:28.
- R7: With `ALT_VARIANT`=1 the base of window i is its map register with every bit below the window size cleared.
- R8: The window sizes are 0x0C000000, 0x10000000 and 0x10000000 when `ALT_VARIANT`=0, and 0x01000000, 0x04000000 and 0x08000000 when `ALT_VARIANT`=1. `win_oor[i]` is 1 exactly when offset i is greater than or equal to the size of window i.
- R9: The translated address is the window base ORed with the offset masked to the smallest power of two that is at least the window size.
- R10: The I/O translator returns `io_off` masked to 20 bits. `io_oor` is 1 exactly when `io_off` is 0x100000 or more, in both variants.
- R11: A write to a window map register leaves translation unchanged during the write cycle. The new base is used from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | OFS_W | Byte offset of the register access |
| reg_wr | input | 1 | Write request |
| reg_rd | input | 1 | Read request |
| reg_be | input | 4 | Byte enables; only 4'hF is a legal access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| reg_err | output | 1 | Access error, one cycle after the request |
| win_off | input | 96 | Window-relative offsets, window i in bits 32i+31:32i |
| win_addr | output | 96 | Translated PCI addresses, same packing |
| win_oor | output | 3 | Per-window out-of-range flags |
| io_off | input | 32 | I/O window offset |
| io_addr | output | 32 | Translated PCI I/O address |
| io_oor | output | 1 | I/O offset outside the 1 MiB window |

## Verification
The bench builds two copies side by side from the same bus and offset stimulus, one with `ALT_VARIANT`=0 and one with `ALT_VARIANT`=1. This puts both base rules and both size tables within reach in a single run. It covers the nibble placement and the alignment mask, and in particular the non-power-of-two first window of the base variant, where the out-of-range limit and the offset mask differ. `OFS_W` stays at 12, so offsets well above the defined map can be probed for the undefined-offset behaviour.

// File: rtl/ibw_pkg.sv
package ibw_pkg;
    localparam int NUM_WIN  = 3;
    localparam int NUM_REGS = 8;
    localparam int DW       = 32;
    localparam logic [DW-1:0] IO_SIZE = 32'h0010_0000;

    typedef enum logic [2:0] {
        IDX_MAP0  = 3'd0,
        IDX_MAP1  = 3'd1,
        IDX_MAP2  = 3'd2,
        IDX_IDENT = 3'd3,
        IDX_FLAGS = 3'd4,
        IDX_SEC0  = 3'd5,
        IDX_SEC1  = 3'd6,
        IDX_SEC2  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic          hit;
        reg_idx_e      idx;
    } reg_dec_t;

    function automatic logic [DW-1:0] win_size(input bit alt, input int idx);
        logic [DW-1:0] s;
        if (alt) begin
            case (idx)
                0:       s = 32'h0100_0000;
                1:       s = 32'h0400_0000;
                default: s = 32'h0800_0000;
            endcase
        end else begin
            case (idx)
                0:       s = 32'h0C00_0000;
                default: s = 32'h1000_0000;
            endcase
        end
        return s;
    endfunction

    function automatic logic [DW-1:0] pow2_mask(input logic [DW-1:0] size);
        logic [DW-1:0] m;
        m = '0;
        for (int b = 0; b < DW; b++) begin
            if (m < size - 1) m = {m[DW-2:0], 1'b1};
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] win_base(input bit alt, input int idx,
                                               input logic [DW-1:0] map);
        if (alt) return map & ~(win_size(1'b1, idx) - 1);
        return {map[3:0], 28'h0};
    endfunction
endpackage

// File: rtl/ibw_regfile.sv
module ibw_regfile
    import ibw_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [OFS_W-1:0]           addr,
    input  logic                       wr,
    input  logic                       rd,
    input  logic [3:0]                 be,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic                       err,
    output logic [NUM_WIN-1:0][DW-1:0] maps
);
    logic [NUM_REGS-1:0][DW-1:0] regs;
    reg_dec_t dec;
    logic     legal;

    always_comb begin
        dec.hit = (addr < OFS_W'(4 * NUM_REGS)) && (addr[1:0] == 2'b00);
        dec.idx = reg_idx_e'(addr[4:2]);
        legal   = dec.hit && (be == 4'hF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs  <= '0;
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            if (wr && legal) regs[dec.idx] <= wdata;
            rdata <= (rd && legal) ? regs[dec.idx] : '0;
            err   <= (rd || wr) && !legal;
        end
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_maps
        assign maps[i] = regs[i];
    end

    assert_err_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
        err |-> rdata == '0);
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd && !wr) |=> (!err && rdata == '0));
    assert_bad_be_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && be != 4'hF) |=> $stable(regs));
    assert_undef_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr >= OFS_W'(4 * NUM_REGS)) |=> $stable(regs));
endmodule

// File: rtl/ibw_win_xlat.sv
module ibw_win_xlat
    import ibw_pkg::*;
#(
    parameter logic [31:0] SIZE = 32'h0010_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] off,
    output logic [DW-1:0] addr,
    output logic          oor
);
    localparam logic [DW-1:0] MASK = pow2_mask(SIZE);

    always_comb begin
        oor  = off >= SIZE;
        addr = base | (off & MASK);
    end

    assert_in_range_sum_R9: assert property (@(posedge clk) disable iff (rst)
        !oor |-> addr == base + off);
    assert_oor_above_R8: assert property (@(posedge clk) disable iff (rst)
        oor |-> off > SIZE - 1);
endmodule

// File: rtl/ibw_xlat_regs.sv
module ibw_xlat_regs
    import ibw_pkg::*;
#(
    parameter bit ALT_VARIANT = 1'b0,
    parameter int OFS_W       = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [OFS_W-1:0]      reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [3:0]            reg_be,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  reg_err,
    input  logic [NUM_WIN*32-1:0] win_off,
    output logic [NUM_WIN*32-1:0] win_addr,
    output logic [NUM_WIN-1:0]    win_oor,
    input  logic [31:0]           io_off,
    output logic [31:0]           io_addr,
    output logic                  io_oor
);
    logic [NUM_WIN-1:0][DW-1:0] maps;
    logic [NUM_WIN-1:0][DW-1:0] bases;

    ibw_regfile #(.OFS_W(OFS_W)) u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .be(reg_be), .wdata(reg_wdata), .rdata(reg_rdata), .err(reg_err),
        .maps(maps)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign bases[i] = win_base(ALT_VARIANT, i, maps[i]);
        ibw_win_xlat #(.SIZE(win_size(ALT_VARIANT, i))) u_xlat (
            .clk(clk), .rst(rst), .base(bases[i]),
            .off(win_off[i*32 +: 32]), .addr(win_addr[i*32 +: 32]),
            .oor(win_oor[i])
        );
    end

    ibw_win_xlat #(.SIZE(IO_SIZE)) u_io (
        .clk(clk), .rst(rst), .base('0), .off(io_off),
        .addr(io_addr), .oor(io_oor)
    );

    if (ALT_VARIANT) begin : g_chk_alt
        assert_map_update_R11: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_be == 4'hF && reg_addr == '0) |=>
            ((win_addr[31:0] & 32'hFF00_0000) == ($past(reg_wdata) & 32'hFF00_0000)));
    end else begin : g_chk_base
        assert_map_update_R11: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_be == 4'hF && reg_addr == '0) |=>
            (win_addr[31:28] == $past(reg_wdata[3:0])));
    end
endmodule

// File: tb/ibw_xlat_regs_bench.sv
module ibw_xlat_regs_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_be = 4'hF;
    logic [31:0] reg_wdata = '0;
    logic [95:0] win_off = '0;
    logic [31:0] io_off = '0;

    logic [31:0] rd_b, rd_a, io_addr_b, io_addr_a;
    logic        err_b, err_a, io_oor_b, io_oor_a;
    logic [95:0] wa_b, wa_a;
    logic [2:0]  oor_b, oor_a;

    ibw_xlat_regs #(.ALT_VARIANT(1'b0)) u_ibw_xlat_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(rd_b), .reg_err(err_b),
        .win_off(win_off), .win_addr(wa_b), .win_oor(oor_b),
        .io_off(io_off), .io_addr(io_addr_b), .io_oor(io_oor_b));

    ibw_xlat_regs #(.ALT_VARIANT(1'b1)) u_ibw_xlat_regs_alt (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(rd_a), .reg_err(err_a),
        .win_off(win_off), .win_addr(wa_a), .win_oor(oor_a),
        .io_off(io_off), .io_addr(io_addr_a), .io_oor(io_oor_a));

    int n_chk = 0, n_fail = 0;
    logic [31:0] shadow [8];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_size(input bit alt, input int i);
        logic [31:0] tb [2][3] = '{'{32'h0C00_0000, 32'h1000_0000, 32'h1000_0000},
                                   '{32'h0100_0000, 32'h0400_0000, 32'h0800_0000}};
        return tb[alt][i];
    endfunction

    function automatic logic [31:0] exp_mask(input bit alt, input int i);
        logic [31:0] tb [2][3] = '{'{32'h0FFF_FFFF, 32'h0FFF_FFFF, 32'h0FFF_FFFF},
                                   '{32'h00FF_FFFF, 32'h03FF_FFFF, 32'h07FF_FFFF}};
        return tb[alt][i];
    endfunction

    function automatic logic [31:0] exp_addr(input bit alt, input int i,
                                             input logic [31:0] map, input logic [31:0] off);
        logic [31:0] b;
        b = alt ? (map & ~exp_mask(1'b1, i)) : (map[3:0] * 32'h1000_0000);
        return b | (off & exp_mask(alt, i));
    endfunction

    // one access; returns data and error of both copies, sampled a cycle later
    task automatic access(input bit w, input logic [11:0] a, input logic [31:0] d,
                          input logic [3:0] be);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_rd = !w; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_be = 4'hF;
    endtask

    task automatic t_reset;
        for (int r = 0; r < 8; r++) begin
            access(1'b0, 12'(4 * r), 0, 4'hF);
            chk(rd_b == 0 && rd_a == 0 && !err_b && !err_a, "R1 reset value", rd_b | rd_a, 0);
        end
    endtask

    task automatic t_rw;
        for (int r = 0; r < 8; r++) begin
            shadow[r] = 32'h1357_9BDF ^ (32'h1111_0101 * (r + 1));
            access(1'b1, 12'(4 * r), shadow[r], 4'hF);
            chk(!err_b && !err_a, "R2 write error flag", {31'b0, err_b | err_a}, 0);
        end
        for (int r = 7; r >= 0; r--) begin
            access(1'b0, 12'(4 * r), 0, 4'hF);
            chk(rd_b == shadow[r] && rd_a == shadow[r], "R2 readback", rd_b, shadow[r]);
        end
    endtask

    task automatic t_undef;
        logic [11:0] bad [4] = '{12'h020, 12'h002, 12'h7FC, 12'h011};
        for (int k = 0; k < 4; k++) begin
            access(1'b1, bad[k], 32'hDEAD_BEEF, 4'hF);
            chk(err_b && err_a, "R3 write error", {31'b0, err_b}, 1);
            access(1'b0, bad[k], 0, 4'hF);
            chk(err_b && rd_b == 0 && rd_a == 0, "R3 read zero", rd_b, 0);
        end
        for (int r = 0; r < 8; r++) begin
            access(1'b0, 12'(4 * r), 0, 4'hF);
            chk(rd_b == shadow[r], "R3 registers unchanged", rd_b, shadow[r]);
        end
    endtask

    task automatic t_partial;
        access(1'b1, 12'h00C, 32'h0BAD_0BAD, 4'h3);
        chk(err_b && err_a, "R4 partial write error", {31'b0, err_b}, 1);
        access(1'b0, 12'h00C, 0, 4'h1);
        chk(err_b && rd_b == 0, "R4 partial read zero", rd_b, 0);
        access(1'b0, 12'h00C, 0, 4'hF);
        chk(rd_b == shadow[3] && !err_b, "R4 register unchanged", rd_b, shadow[3]);
    endtask

    task automatic t_timing;
        access(1'b0, 12'h020, 0, 4'hF);
        chk(err_b, "R5 error in next cycle", {31'b0, err_b}, 1);
        @(negedge clk);
        chk(!err_b && rd_b == 0 && !err_a && rd_a == 0, "R5 idle quiet", rd_b, 0);
    endtask

    task automatic t_xlat(input logic [31:0] map0, input logic [31:0] off);
        for (int i = 0; i < 3; i++) win_off[i*32 +: 32] = off;
        #1;
        for (int i = 0; i < 3; i++) begin
            logic [31:0] m;
            m = (i == 0) ? map0 : shadow[i];
            chk(wa_b[i*32 +: 32] == exp_addr(1'b0, i, m, off), "R6 R9 base-variant address",
                wa_b[i*32 +: 32], exp_addr(1'b0, i, m, off));
            chk(wa_a[i*32 +: 32] == exp_addr(1'b1, i, m, off), "R7 R9 alt-variant address",
                wa_a[i*32 +: 32], exp_addr(1'b1, i, m, off));
            chk(oor_b[i] == (off >= exp_size(1'b0, i)), "R8 base-variant range",
                {31'b0, oor_b[i]}, {31'b0, off >= exp_size(1'b0, i)});
            chk(oor_a[i] == (off >= exp_size(1'b1, i)), "R8 alt-variant range",
                {31'b0, oor_a[i]}, {31'b0, off >= exp_size(1'b1, i)});
        end
    endtask

    task automatic t_io(input logic [31:0] off);
        @(negedge clk);
        io_off = off;
        #1;
        chk(io_addr_b == (off & 32'h000F_FFFF) && io_addr_a == io_addr_b,
            "R10 io address", io_addr_b, off & 32'h000F_FFFF);
        chk(io_oor_b == (off >= 32'h0010_0000) && io_oor_a == io_oor_b,
            "R10 io range", {31'b0, io_oor_b}, {31'b0, off >= 32'h0010_0000});
    endtask

    task automatic t_update;
        logic [31:0] old_map, new_map;
        old_map = shadow[0];
        new_map = 32'h5A3C_F00E;
        win_off[31:0] = 32'h0012_3456;
        @(negedge clk);
        reg_addr = 12'h000; reg_wr = 1'b1; reg_be = 4'hF; reg_wdata = new_map;
        #1;
        chk(wa_b[31:0] == exp_addr(1'b0, 0, old_map, 32'h0012_3456), "R11 old base during write",
            wa_b[31:0], exp_addr(1'b0, 0, old_map, 32'h0012_3456));
        chk(wa_a[31:0] == exp_addr(1'b1, 0, old_map, 32'h0012_3456), "R11 old alt base during write",
            wa_a[31:0], exp_addr(1'b1, 0, old_map, 32'h0012_3456));
        @(negedge clk);
        reg_wr = 1'b0;
        shadow[0] = new_map;
        chk(wa_b[31:0] == exp_addr(1'b0, 0, new_map, 32'h0012_3456), "R11 new base after write",
            wa_b[31:0], exp_addr(1'b0, 0, new_map, 32'h0012_3456));
        chk(wa_a[31:0] == exp_addr(1'b1, 0, new_map, 32'h0012_3456), "R11 new alt base after write",
            wa_a[31:0], exp_addr(1'b1, 0, new_map, 32'h0012_3456));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rw();
        t_undef();
        t_partial();
        t_timing();
        t_xlat(shadow[0], 32'h0012_3456);
        t_xlat(shadow[0], 32'h0BFF_FFFF);
        t_xlat(shadow[0], 32'h0C00_0000);
        t_xlat(shadow[0], 32'h0FFF_FFFF);
        t_xlat(shadow[0], 32'h1234_5678);
        t_io(32'h0000_0000);
        t_io(32'h000F_FFFF);
        t_io(32'h0010_0000);
        t_update();
        t_xlat(shadow[0], 32'h03FF_FFFC);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule